// File: doc/BRIEF.md
# Calendar Real-Time Clock

The block keeps wall-clock time and calendar date: seconds, minutes, hours, day of month, weekday, month and a 12-bit year. A one-cycle `tick` pulse, produced elsewhere once per second, advances the count. Each count follows the rules of the calendar: sixty-second minutes, twenty-four-hour days, month lengths by month, and a leap February in every year divisible by four.

Software uses a small synchronous register bus. It can write a time-set word, a date-set word and a year word. It can read back a current-time word and a current-date word. Two control bits sit in the upper part of each set word: a hold bit at bit 24 and a load bit at bit 25. To load new values, software first writes the word with hold only, then with hold and load, then with hold only again, and finally with both bits clear. The clock stays frozen while hold is in force. It takes the new fields when the load bit rises while hold is already held. Time and date each have their own handshake.

Word addresses on `bus_addr`: 0 time-set, 1 date-set, 2 year, 3 current time, 4 current date.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the clock reads 00:00:00 on day 1, month 1, year 2000, weekday 6, and it is not held.
- R2: A `tick` that is not held raises seconds by one. Seconds at 59 go to 0 and carry into minutes. Minutes at 59 go to 0 and carry into hours. Hours at 23 go to 0 and carry into the date. Cycles without `tick` change nothing.
- R3: A read of address 3 returns hours in bits 20:16, minutes in 13:8 and seconds in 5:0, with every other bit 0. `bus_rdata` holds this value from the cycle after the one in which `bus_rd` is sampled.
- R4: A read of address 4 returns month in bits 27:24, weekday in 23:21, day of month in 20:16 and year in 11:0, with every other bit 0.
- R5: The most recent write to a set register fixes that register's hold state from bit 24. While either hold state is set, ticks advance nothing.
- R6: A time-set write that has bits 25 and 24 both set loads the time fields, but only when the previous time-set write had bit 24 set and bit 25 clear. The fields taken are hours from bits 20:16, minutes from 13:8 and seconds from 5:0. All other bits are ignored.
- R7: A date-set write under the same handshake rule loads the date fields: month from bits 19:16, weekday from 10:8 and day from 4:0. It also loads the year most recently written to address 2 (bits 11:0, upper bits ignored). All other bits are ignored.
- R8: A write with bits 25 and 24 both set loads nothing when it does not follow a hold-only write to the same register.
- R9: The day rolls over to 1 after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 30 in months 4, 6, 9 and 11. In February it rolls over after day 29 when the year is divisible by 4, and after day 28 otherwise. Each rollover raises the month by one.
- R10: Month 12 rolls over to month 1 and the year rises by one. At every day rollover the weekday steps from 7 to 1 and otherwise rises by one.
- R11: A weekday field of 0 in a date load is stored as 7, so the weekday never reads 0.
- R12: A time load leaves the date unchanged, and a date load leaves the time unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The assertions assume three things about the inputs: `tick` is a single-cycle pulse, loads come only through the full four-write handshake, and no tick arrives while a load is in progress. The stimulus meets these conditions. Ticks are separated by an idle cycle, every load task issues the complete hold, hold-and-load, hold, clear sequence, and ticks are only applied after the final clear write. The randomized part draws only legal field values, placed close to second, day, month and year boundaries so that the carries actually occur. The directed cases cover junk bits in the set words, a load attempt without the hold step, and a zero weekday.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HR_W   = 5;
  localparam int DAY_W  = 5;
  localparam int WD_W   = 3;
  localparam int MON_W  = 4;
  localparam int YR_W   = 12;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_TSET  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DSET  = 3'd1;
  localparam logic [ADDR_W-1:0] A_YEAR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTIME = 3'd3;
  localparam logic [ADDR_W-1:0] A_CDATE = 3'd4;

  localparam int B_HOLD = 24;
  localparam int B_LOAD = 25;

  function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] mo,
                                                  input logic [YR_W-1:0] yr);
    case (mo)
      4'd2:                    return (yr[1:0] == 2'b00) ? DAY_W'(29) : DAY_W'(28);
      4'd4, 4'd6, 4'd9, 4'd11: return DAY_W'(30);
      default:                 return DAY_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/rtc_set_ctrl.sv
module rtc_set_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic hold_bit,
  input  logic load_bit,
  output logic held,
  output logic load
);
  logic hold_q, hold_d;
  logic ld_q, ld_d;

  always_comb begin
    hold_d = hold_q;
    ld_d   = ld_q;
    if (wr) begin
      hold_d = hold_bit;
      ld_d   = load_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      ld_q   <= 1'b0;
    end else if (wr) begin
      hold_q <= hold_d;
      ld_q   <= ld_d;
    end
  end

  assign load = wr & hold_bit & load_bit & hold_q & ~ld_q;
  assign held = hold_q;

  AST_HOLD_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> held == $past(hold_bit)); // R5
  AST_LOAD_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> held); // R6
endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
  import rtc_cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic [HR_W-1:0]  ld_hr,
  input  logic [MIN_W-1:0] ld_min,
  input  logic [SEC_W-1:0] ld_sec,
  output logic [HR_W-1:0]  hr,
  output logic [MIN_W-1:0] min,
  output logic [SEC_W-1:0] sec,
  output logic             day_carry
);
  localparam logic [SEC_W-1:0] SEC_TOP = SEC_W'(59);
  localparam logic [MIN_W-1:0] MIN_TOP = MIN_W'(59);
  localparam logic [HR_W-1:0]  HR_TOP  = HR_W'(23);

  logic [HR_W-1:0]  hr_d;
  logic [MIN_W-1:0] min_d;
  logic [SEC_W-1:0] sec_d;
  logic             en;
  logic             sec_end, min_end, hr_end;

  assign sec_end = (sec >= SEC_TOP);
  assign min_end = (min >= MIN_TOP);
  assign hr_end  = (hr  >= HR_TOP);
  assign en      = adv | load;

  always_comb begin
    hr_d  = hr;
    min_d = min;
    sec_d = sec;
    if (load) begin
      hr_d  = ld_hr;
      min_d = ld_min;
      sec_d = ld_sec;
    end else if (adv) begin
      if (!sec_end) begin
        sec_d = sec + 1'b1;
      end else begin
        sec_d = '0;
        if (!min_end) begin
          min_d = min + 1'b1;
        end else begin
          min_d = '0;
          hr_d  = hr_end ? '0 : hr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hr  <= '0;
      min <= '0;
      sec <= '0;
    end else if (en) begin
      hr  <= hr_d;
      min <= min_d;
      sec <= sec_d;
    end
  end

  assign day_carry = adv & ~load & sec_end & min_end & hr_end;

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load && sec >= SEC_TOP |=> sec == 0); // R2
  AST_TIME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !load |=> $stable(sec) && $stable(min) && $stable(hr)); // R5
endmodule

// File: rtl/rtc_date_cnt.sv
module rtc_date_cnt
  import rtc_cal_pkg::*;
#(
  parameter int RST_YEAR = 2000,
  parameter int RST_WDAY = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_day,
  input  logic             load,
  input  logic [DAY_W-1:0] ld_day,
  input  logic [WD_W-1:0]  ld_wd,
  input  logic [MON_W-1:0] ld_mon,
  input  logic [YR_W-1:0]  ld_yr,
  output logic [DAY_W-1:0] day,
  output logic [WD_W-1:0]  wd,
  output logic [MON_W-1:0] mon,
  output logic [YR_W-1:0]  yr
);
  localparam logic [WD_W-1:0]  WD_TOP  = WD_W'(7);
  localparam logic [MON_W-1:0] MON_TOP = MON_W'(12);

  logic [DAY_W-1:0] day_d, dim;
  logic [WD_W-1:0]  wd_d;
  logic [MON_W-1:0] mon_d;
  logic [YR_W-1:0]  yr_d;
  logic             en;

  assign dim = month_len(mon, yr);
  assign en  = adv_day | load;

  always_comb begin
    day_d = day;
    wd_d  = wd;
    mon_d = mon;
    yr_d  = yr;
    if (load) begin
      day_d = ld_day;
      wd_d  = (ld_wd == '0) ? WD_TOP : ld_wd;
      mon_d = ld_mon;
      yr_d  = ld_yr;
    end else if (adv_day) begin
      wd_d = (wd >= WD_TOP) ? WD_W'(1) : wd + 1'b1;
      if (day < dim) begin
        day_d = day + 1'b1;
      end else begin
        day_d = DAY_W'(1);
        if (mon < MON_TOP) begin
          mon_d = mon + 1'b1;
        end else begin
          mon_d = MON_W'(1);
          yr_d  = yr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day <= DAY_W'(1);
      wd  <= WD_W'(RST_WDAY);
      mon <= MON_W'(1);
      yr  <= YR_W'(RST_YEAR);
    end else if (en) begin
      day <= day_d;
      wd  <= wd_d;
      mon <= mon_d;
      yr  <= yr_d;
    end
  end

  AST_WD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wd != 0); // R11
  AST_DAY_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    adv_day && !load && day >= dim |=> day == 1); // R9
  AST_YEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_day && !load && day >= dim && mon >= MON_TOP |=>
      mon == 1 && yr == $past(yr) + 1'b1); // R10
  AST_WD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_day && !load && wd >= WD_TOP |=> wd == 1); // R10
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int RST_YEAR = 2000,
  parameter int RST_WDAY = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic t_held, d_held, t_load, d_load, adv, day_carry;
  logic wr_t, wr_d, wr_y;
  logic [HR_W-1:0]   hr;
  logic [MIN_W-1:0]  min;
  logic [SEC_W-1:0]  sec;
  logic [DAY_W-1:0]  day;
  logic [WD_W-1:0]   wd;
  logic [MON_W-1:0]  mon;
  logic [YR_W-1:0]   yr;
  logic [YR_W-1:0]   yr_stage, yr_stage_d;
  logic [DATA_W-1:0] rdata_d;

  assign wr_t = bus_wr && (bus_addr == A_TSET);
  assign wr_d = bus_wr && (bus_addr == A_DSET);
  assign wr_y = bus_wr && (bus_addr == A_YEAR);

  rtc_set_ctrl u_tctl (
    .clk(clk), .rst_n(rst_n), .wr(wr_t),
    .hold_bit(bus_wdata[B_HOLD]), .load_bit(bus_wdata[B_LOAD]),
    .held(t_held), .load(t_load));

  rtc_set_ctrl u_dctl (
    .clk(clk), .rst_n(rst_n), .wr(wr_d),
    .hold_bit(bus_wdata[B_HOLD]), .load_bit(bus_wdata[B_LOAD]),
    .held(d_held), .load(d_load));

  assign adv = tick & ~t_held & ~d_held;

  rtc_time_cnt u_time (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(t_load),
    .ld_hr(bus_wdata[16 +: HR_W]), .ld_min(bus_wdata[8 +: MIN_W]),
    .ld_sec(bus_wdata[0 +: SEC_W]),
    .hr(hr), .min(min), .sec(sec), .day_carry(day_carry));

  rtc_date_cnt #(.RST_YEAR(RST_YEAR), .RST_WDAY(RST_WDAY)) u_date (
    .clk(clk), .rst_n(rst_n), .adv_day(day_carry), .load(d_load),
    .ld_day(bus_wdata[0 +: DAY_W]), .ld_wd(bus_wdata[8 +: WD_W]),
    .ld_mon(bus_wdata[16 +: MON_W]), .ld_yr(yr_stage),
    .day(day), .wd(wd), .mon(mon), .yr(yr));

  assign yr_stage_d = bus_wdata[YR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) yr_stage <= YR_W'(RST_YEAR);
    else if (wr_y) yr_stage <= yr_stage_d;
  end

  always_comb begin
    rdata_d = '0;
    case (bus_addr)
      A_CTIME: begin
        rdata_d[16 +: HR_W]  = hr;
        rdata_d[8 +: MIN_W]  = min;
        rdata_d[0 +: SEC_W]  = sec;
      end
      A_CDATE: begin
        rdata_d[24 +: MON_W] = mon;
        rdata_d[21 +: WD_W]  = wd;
        rdata_d[16 +: DAY_W] = day;
        rdata_d[0 +: YR_W]   = yr;
      end
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_d;
  end

  AST_TIME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    t_load |=> hr == $past(bus_wdata[20:16]) && min == $past(bus_wdata[13:8])
               && sec == $past(bus_wdata[5:0])); // R6
  AST_DATE_KEPT_ON_TLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    t_load && !d_load |=> $stable(day) && $stable(mon) && $stable(yr) && $stable(wd)); // R12
  AST_TIME_KEPT_ON_DLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    d_load && !t_load |=> $stable(sec) && $stable(min) && $stable(hr)); // R12
  AST_HELD_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (t_held || d_held) && !t_load |=> $stable(sec)); // R5
endmodule

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  int m_h, m_m, m_s, m_d, m_wd, m_mo, m_y;

  localparam logic [31:0] TJUNK = 32'hFCE0_C0C0;
  localparam logic [31:0] DJUNK = 32'hFCE0_F8E0;

  always #2 clk = ~clk;

  rtc_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic int mlen(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] exp_time();
    return (32'(m_h) << 16) | (32'(m_m) << 8) | 32'(m_s);
  endfunction

  function automatic logic [31:0] exp_date();
    return (32'(m_mo) << 24) | (32'(m_wd) << 21) | (32'(m_d) << 16) | 32'(m_y);
  endfunction

  task automatic model_sec();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_m++;
      if (m_m == 60) begin
        m_m = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0;
          m_wd = (m_wd == 7) ? 1 : m_wd + 1;
          if (m_d >= mlen(m_mo, m_y)) begin
            m_d = 1;
            if (m_mo == 12) begin m_mo = 1; m_y = (m_y + 1) % 4096; end
            else m_mo++;
          end else m_d++;
        end
      end
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_ticks(int n, bit advance);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (advance) model_sec();
    end
  endtask

  task automatic load_time(int h, int m, int s, logic [31:0] junk);
    logic [31:0] f;
    f = (32'(h) << 16) | (32'(m) << 8) | 32'(s) | junk;
    bus_write(3'd0, f | 32'h0100_0000);
    bus_write(3'd0, f | 32'h0300_0000);
    bus_write(3'd0, f | 32'h0100_0000);
    bus_write(3'd0, f & 32'hFCFF_FFFF);
    m_h = h; m_m = m; m_s = s;
  endtask

  task automatic load_date(int y, int mo, int w, int d, logic [31:0] junk);
    logic [31:0] f;
    f = (32'(mo) << 16) | (32'(w) << 8) | 32'(d) | junk;
    bus_write(3'd2, 32'(y) | (junk & 32'hFFFF_F000));
    bus_write(3'd1, f | 32'h0100_0000);
    bus_write(3'd1, f | 32'h0300_0000);
    bus_write(3'd1, f | 32'h0100_0000);
    bus_write(3'd1, f & 32'hFCFF_FFFF);
    m_y = y; m_mo = mo; m_d = d; m_wd = (w == 0) ? 7 : w;
  endtask

  task automatic check_both(string req);
    logic [31:0] r;
    bus_read(3'd3, r); check(req, r, exp_time());
    bus_read(3'd4, r); check(req, r, exp_date());
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    m_h = 0; m_m = 0; m_s = 0; m_d = 1; m_wd = 6; m_mo = 1; m_y = 2000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R3/R4 literal layouts
    bus_read(3'd3, r); check("R1 reset time", r, 32'h0);
    bus_read(3'd4, r); check("R1 R4 reset date", r, 32'h01C1_07D0);

    // R2 ticks, R3 layout
    repeat (5) @(negedge clk);
    do_ticks(3, 1);
    bus_read(3'd3, r); check("R2 R3 three ticks", r, 32'h0000_0003);

    // R5 hold freezes counting; fields in a hold-only write not loaded
    bus_write(3'd0, 32'h0100_0000 | (32'd5 << 16) | 32'd9);
    do_ticks(4, 0);
    bus_read(3'd3, r); check("R5 held time", r, exp_time());
    bus_write(3'd0, 32'h0);

    // R6 load with junk bits, R12 date unchanged
    load_time(23, 59, 58, TJUNK);
    check_both("R6 R12 time load");

    // R8 load bits without preceding hold-only write
    bus_write(3'd0, 32'h0300_0000 | (32'd1 << 16) | (32'd2 << 8) | 32'd3);
    bus_write(3'd0, 32'h0);
    bus_read(3'd3, r); check("R8 no load", r, exp_time());

    // R2 carry into date, R10 weekday 6->7
    do_ticks(3, 1);
    check_both("R2 R10 midnight");

    // R7 date load with junk, R12 time unchanged, R9 leap Feb, R10 wd 7->1
    load_date(2004, 2, 7, 28, DJUNK);
    check_both("R7 R12 date load");
    load_time(23, 59, 59, 32'h0);
    do_ticks(1, 1);
    bus_read(3'd4, r); check("R9 R10 leap feb 29", r, exp_date());
    load_time(23, 59, 59, 32'h0);
    do_ticks(1, 1);
    bus_read(3'd4, r); check("R9 leap feb to mar", r, exp_date());

    load_date(2003, 2, 3, 28, 32'h0);
    load_time(23, 59, 59, 32'h0);
    do_ticks(1, 1);
    bus_read(3'd4, r); check("R9 common feb to mar", r, exp_date());

    load_date(2001, 4, 2, 30, 32'h0);
    load_time(23, 59, 59, 32'h0);
    do_ticks(1, 1);
    bus_read(3'd4, r); check("R9 30-day month", r, exp_date());

    load_date(2005, 12, 5, 31, 32'h0);
    load_time(23, 59, 59, 32'h0);
    do_ticks(1, 1);
    check_both("R10 new year");

    // R11 weekday zero stored as seven
    load_date(2010, 6, 0, 15, 32'h0);
    bus_read(3'd4, r); check("R11 weekday zero", r, exp_date());

    // constrained random near boundaries
    for (int it = 0; it < 40; it++) begin
      int y, mo, d, w, s, mi, n;
      y  = $urandom % 4096;
      mo = 1 + $urandom % 12;
      d  = mlen(mo, y) - ($urandom % 2);
      w  = 1 + $urandom % 7;
      mi = 58 + $urandom % 2;
      s  = 50 + $urandom % 10;
      n  = $urandom % 16;
      load_date(y, mo, w, d, 32'h0);
      load_time(23, mi, s, 32'h0);
      do_ticks(n, 1);
      check_both("R2 R9 R10 random");
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule